// File: doc/BRIEF.md
# Transmit Descriptor Chain DMA Engine

This engine moves outgoing frames from memory to a byte stream. Software builds a chain of 16-byte descriptors in memory. Each descriptor holds four little-endian 32-bit words at ascending offsets: flags at +0, buffer address at +4, status-and-length at +8 and next-descriptor address at +12. Software marks each descriptor as hardware-owned and then pulses the poll input while transmit is enabled. The engine reads the descriptor. It streams the payload bytes out in address order, writes completion status back into the descriptor and returns ownership to software. It then follows the next-descriptor pointer to the next descriptor.

Processing ends at the first descriptor that software owns. The engine reports that no descriptor is available and keeps that descriptor's address as its current pointer. A later poll resumes from that address. The list start address can only be loaded after a reset or a software reset, and the next accepted poll consumes it. A memory error response stops the engine until a reset. Framing, checksums and padding are handled downstream.

Top module: `txring_dma`

## Requirements
- R1: After `rst` or `sw_reset`, `mem_req` and `byte_valid` are low, `cur_desc` is 0 and no event pulses. While `mem_req` is high and `mem_ack` is low, the request address, direction and write data hold steady.
- R2: A `poll` pulse with `tx_enable` high starts a run. A `poll` pulse with `tx_enable` low starts nothing. A run reads the descriptor words in the order +0, +4, +8, +12.
- R3: A descriptor whose flags bit 31 is 0 ends the run without reading its other words. `ev_no_desc` pulses once and `cur_desc` holds that descriptor's address.
- R4: The payload is the byte count in status bits 15:0, taken from the buffer address in the +4 word. Any byte alignment is allowed. Bytes come out in ascending address order, with byte lane k of a memory word holding bits 8k+7:8k. `byte_last` marks the final byte. A length of 0 produces no bytes.
- R5: Write-back stores the status word at +8 first, with bit 19 set and bit 16 equal to flags bit 2, all other bits unchanged. It then stores the flags word at +0 with bit 31 cleared and all other bits unchanged.
- R6: Every completed descriptor pulses `ev_frame_done` and `ev_frame_int` together for one cycle, after the flags write is acknowledged.
- R7: After a completed descriptor, the next descriptor fetched is the one at the address held in the +12 word, whether or not it is adjacent in memory.
- R8: `base_wr` loads the list start only between a reset (or `sw_reset`) and the next accepted poll, and that poll starts fetching at the loaded address. At any other time `base_wr` is ignored.
- R9: A `mem_err` response pulses `ev_bus_err`, stops the run with no write-back, and makes the engine ignore `poll` until `sw_reset`.
- R10: A `poll` during a run is ignored. A `poll` after a stop resumes fetching at `cur_desc`.
- R11: While `byte_ready` is low, `byte_valid`, `byte_data` and `byte_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_reset | input | 1 | Synchronous software reset, same effect as rst |
| tx_enable | input | 1 | Transmit enable; gates poll |
| poll | input | 1 | Pulse to start descriptor processing |
| base_wr | input | 1 | List start address write strobe |
| base_data | input | 32 | List start address |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed this cycle |
| mem_err | input | 1 | Error response, valid with mem_ack |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| byte_valid | output | 1 | Payload byte available |
| byte_data | output | 8 | Payload byte |
| byte_last | output | 1 | Final byte of the descriptor's payload |
| byte_ready | input | 1 | Sink accepts the byte |
| cur_desc | output | 32 | Current descriptor pointer |
| ev_frame_done | output | 1 | Completion event pulse |
| ev_frame_int | output | 1 | Transmit interrupt event pulse |
| ev_no_desc | output | 1 | No descriptor available event pulse |
| ev_bus_err | output | 1 | Memory error event pulse |

## Verification
The hardest states to reach from the ports are the restart paths. These are a poll that arrives while a chain is still running, a base write that arrives after the window has closed, and a poll after a memory error. The bench reaches them by running a chain in which the descriptors are not adjacent in memory, and sending a second poll in the middle of it. It then writes a new base without a software reset and polls again. The check is that fetching resumes at the stopped pointer and not at the new base. The error case plants an error response on a payload word. The bench then confirms the descriptor was not written back and that later polls produce no memory traffic until a software reset. Throughout, the byte sink stalls on alternate cycles, so byte hold and the word-to-byte boundaries are exercised at every buffer alignment.

// File: rtl/txr_pkg.sv
package txr_pkg;
    localparam int ADDR_W      = 32;
    localparam int WORD_W      = 32;
    localparam int LEN_W       = 16;
    localparam int LANES       = WORD_W / 8;
    localparam int LANE_W      = $clog2(LANES);
    localparam int CNT_W       = LANE_W + 1;
    localparam int OWN_BIT     = 31;
    localparam int IE_BIT      = 2;
    localparam int ST_DONE_BIT = 19;
    localparam int ST_INT_BIT  = 16;

    typedef enum logic [3:0] {
        S_IDLE, S_RD_FLAGS, S_RD_BUF, S_RD_LEN, S_RD_NEXT,
        S_PL_RD, S_PL_EMIT, S_WB_STAT, S_WB_FLAGS, S_HALT
    } seq_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] flags;
        logic [WORD_W-1:0] stat_len;
        logic [ADDR_W-1:0] next;
    } desc_t;

    function automatic logic [WORD_W-1:0] done_status(input logic [WORD_W-1:0] sl,
                                                      input logic ie);
        logic [WORD_W-1:0] r;
        r = sl;
        r[ST_DONE_BIT] = 1'b1;
        r[ST_INT_BIT]  = ie;
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] release_flags(input logic [WORD_W-1:0] f);
        logic [WORD_W-1:0] r;
        r = f;
        r[OWN_BIT] = 1'b0;
        return r;
    endfunction
endpackage

// File: rtl/txr_base_gate.sv
module txr_base_gate
    import txr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              start,
    output logic [ADDR_W-1:0] base,
    output logic              open
);
    always_ff @(posedge clk) begin
        if (rst) begin
            base <= '0;
            open <= 1'b1;
        end else begin
            if (wr && open) base <= wdata;
            if (start) open <= 1'b0;
        end
    end

    // R8: once the window is closed the stored base cannot change
    a_r8_base_frozen: assert property (@(posedge clk) disable iff (rst)
        (!open && wr) |=> $stable(base));
endmodule

// File: rtl/txr_byte_unpack.sv
module txr_byte_unpack
    import txr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic [LANE_W-1:0] lane,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              last,
    output logic              busy,
    output logic              byte_valid,
    output logic [7:0]        byte_data,
    output logic              byte_last,
    input  logic              byte_ready
);
    logic [WORD_W-1:0] word_q;
    logic [LANE_W-1:0] lane_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            lane_q <= '0;
            cnt_q  <= '0;
            last_q <= 1'b0;
        end else if (load) begin
            word_q <= word;
            lane_q <= lane;
            cnt_q  <= cnt;
            last_q <= last;
        end else if (byte_valid && byte_ready) begin
            lane_q <= lane_q + 1'b1;
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign busy       = (cnt_q != '0);
    assign byte_valid = busy;
    assign byte_data  = word_q[{lane_q, 3'b000} +: 8];
    assign byte_last  = last_q && (cnt_q == CNT_W'(1));

    a_r11_hold_stalled: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && !byte_ready && !load) |=>
            (byte_valid && $stable(byte_data) && $stable(byte_last)));
    a_r4_last_is_valid: assert property (@(posedge clk) disable iff (rst)
        byte_last |-> byte_valid);
endmodule

// File: rtl/txr_seq.sv
module txr_seq
    import txr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              poll,
    input  logic              tx_enable,
    input  logic              base_open,
    input  logic [ADDR_W-1:0] list_base,
    output logic              start,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              up_load,
    output logic [LANE_W-1:0] up_lane,
    output logic [CNT_W-1:0]  up_cnt,
    output logic              up_last,
    input  logic              up_busy,
    output logic [ADDR_W-1:0] cur_desc,
    output logic              ev_done,
    output logic              ev_int,
    output logic              ev_nodesc,
    output logic              ev_buserr
);
    seq_state_t        state;
    desc_t             d;
    logic [ADDR_W-1:0] ptr;
    logic [ADDR_W-1:0] pay_addr;
    logic [LEN_W-1:0]  rem;
    logic [CNT_W-1:0]  avail;
    logic [CNT_W-1:0]  take;
    logic              hit;

    assign hit   = mem_req && mem_ack;
    assign start = (state == S_IDLE) && poll && tx_enable;
    assign avail = CNT_W'(LANES) - {1'b0, pay_addr[LANE_W-1:0]};
    assign take  = (rem < LEN_W'(avail)) ? rem[CNT_W-1:0] : avail;

    assign up_load = (state == S_PL_RD) && hit && !mem_err;
    assign up_lane = pay_addr[LANE_W-1:0];
    assign up_cnt  = take;
    assign up_last = (rem == LEN_W'(take));
    assign cur_desc = ptr;

    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_addr  = ptr;
        mem_wdata = '0;
        case (state)
            S_RD_FLAGS: mem_addr = ptr;
            S_RD_BUF:   mem_addr = ptr + ADDR_W'(4);
            S_RD_LEN:   mem_addr = ptr + ADDR_W'(8);
            S_RD_NEXT:  mem_addr = ptr + ADDR_W'(12);
            S_PL_RD:    mem_addr = {pay_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
            S_WB_STAT: begin
                mem_we    = 1'b1;
                mem_addr  = ptr + ADDR_W'(8);
                mem_wdata = done_status(d.stat_len, d.flags[IE_BIT]);
            end
            S_WB_FLAGS: begin
                mem_we    = 1'b1;
                mem_wdata = release_flags(d.flags);
            end
            default: mem_req = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            d         <= '0;
            ptr       <= '0;
            pay_addr  <= '0;
            rem       <= '0;
            ev_done   <= 1'b0;
            ev_int    <= 1'b0;
            ev_nodesc <= 1'b0;
            ev_buserr <= 1'b0;
        end else begin
            ev_done   <= 1'b0;
            ev_int    <= 1'b0;
            ev_nodesc <= 1'b0;
            ev_buserr <= 1'b0;
            if (hit && mem_err) begin
                state     <= S_HALT;
                ev_buserr <= 1'b1;
            end else begin
                case (state)
                    S_IDLE: if (start) begin
                        if (base_open) ptr <= list_base;
                        state <= S_RD_FLAGS;
                    end
                    S_RD_FLAGS: if (hit) begin
                        if (mem_rdata[OWN_BIT]) begin
                            d.flags <= mem_rdata;
                            state   <= S_RD_BUF;
                        end else begin
                            ev_nodesc <= 1'b1;
                            state     <= S_IDLE;
                        end
                    end
                    S_RD_BUF: if (hit) begin
                        pay_addr <= mem_rdata;
                        state    <= S_RD_LEN;
                    end
                    S_RD_LEN: if (hit) begin
                        d.stat_len <= mem_rdata;
                        rem        <= mem_rdata[LEN_W-1:0];
                        state      <= S_RD_NEXT;
                    end
                    S_RD_NEXT: if (hit) begin
                        d.next <= mem_rdata;
                        state  <= (rem == '0) ? S_WB_STAT : S_PL_RD;
                    end
                    S_PL_RD: if (hit) begin
                        pay_addr <= pay_addr + ADDR_W'(take);
                        rem      <= rem - LEN_W'(take);
                        state    <= S_PL_EMIT;
                    end
                    S_PL_EMIT: if (!up_busy) begin
                        state <= (rem == '0) ? S_WB_STAT : S_PL_RD;
                    end
                    S_WB_STAT: if (hit) state <= S_WB_FLAGS;
                    S_WB_FLAGS: if (hit) begin
                        ev_done <= 1'b1;
                        ev_int  <= 1'b1;
                        ptr     <= d.next;
                        state   <= S_RD_FLAGS;
                    end
                    default: state <= S_HALT;
                endcase
            end
        end
    end

    a_r1_req_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
    a_r5_flags_follow_status: assert property (@(posedge clk) disable iff (rst)
        (state == S_WB_STAT && hit && !mem_err) |=>
            (mem_req && mem_we && !mem_wdata[OWN_BIT]
             && mem_addr == $past(mem_addr) - ADDR_W'(8)));
    a_r6_done_after_write: assert property (@(posedge clk) disable iff (rst)
        ev_done |-> $past(mem_req && mem_we && mem_ack && !mem_err));
    a_r3_stop_quiet: assert property (@(posedge clk) disable iff (rst)
        ev_nodesc |-> !mem_req);
    a_r9_halt_quiet: assert property (@(posedge clk) disable iff (rst)
        ev_buserr |=> !mem_req);
endmodule

// File: rtl/txring_dma.sv
module txring_dma
    import txr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_reset,
    input  logic              tx_enable,
    input  logic              poll,
    input  logic              base_wr,
    input  logic [ADDR_W-1:0] base_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              byte_valid,
    output logic [7:0]        byte_data,
    output logic              byte_last,
    input  logic              byte_ready,
    output logic [ADDR_W-1:0] cur_desc,
    output logic              ev_frame_done,
    output logic              ev_frame_int,
    output logic              ev_no_desc,
    output logic              ev_bus_err
);
    logic              rst_any;
    logic              start;
    logic              base_open;
    logic [ADDR_W-1:0] list_base;
    logic              up_load;
    logic [LANE_W-1:0] up_lane;
    logic [CNT_W-1:0]  up_cnt;
    logic              up_last;
    logic              up_busy;

    assign rst_any = rst || sw_reset;

    txr_base_gate u_gate (
        .clk   (clk),
        .rst   (rst_any),
        .wr    (base_wr),
        .wdata (base_data),
        .start (start),
        .base  (list_base),
        .open  (base_open)
    );

    txr_seq u_seq (
        .clk       (clk),
        .rst       (rst_any),
        .poll      (poll),
        .tx_enable (tx_enable),
        .base_open (base_open),
        .list_base (list_base),
        .start     (start),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_err   (mem_err),
        .mem_rdata (mem_rdata),
        .up_load   (up_load),
        .up_lane   (up_lane),
        .up_cnt    (up_cnt),
        .up_last   (up_last),
        .up_busy   (up_busy),
        .cur_desc  (cur_desc),
        .ev_done   (ev_frame_done),
        .ev_int    (ev_frame_int),
        .ev_nodesc (ev_no_desc),
        .ev_buserr (ev_bus_err)
    );

    txr_byte_unpack u_unpack (
        .clk        (clk),
        .rst        (rst_any),
        .load       (up_load),
        .word       (mem_rdata),
        .lane       (up_lane),
        .cnt        (up_cnt),
        .last       (up_last),
        .busy       (up_busy),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .byte_last  (byte_last),
        .byte_ready (byte_ready)
    );
endmodule

// File: tb/txring_dma_tb_top.sv
module txring_dma_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sw_reset = 1'b0;
    logic        tx_enable = 1'b0;
    logic        poll = 1'b0;
    logic        base_wr = 1'b0;
    logic [31:0] base_data = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic        mem_err = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        byte_valid, byte_last;
    logic [7:0]  byte_data;
    logic        byte_ready;
    logic [31:0] cur_desc;
    logic        ev_frame_done, ev_frame_int, ev_no_desc, ev_bus_err;

    always #5 clk = ~clk;

    txring_dma dut_i (
        .clk(clk), .rst(rst), .sw_reset(sw_reset), .tx_enable(tx_enable),
        .poll(poll), .base_wr(base_wr), .base_data(base_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .mem_rdata(mem_rdata), .byte_valid(byte_valid), .byte_data(byte_data),
        .byte_last(byte_last), .byte_ready(byte_ready), .cur_desc(cur_desc),
        .ev_frame_done(ev_frame_done), .ev_frame_int(ev_frame_int),
        .ev_no_desc(ev_no_desc), .ev_bus_err(ev_bus_err)
    );

    logic [31:0] mem [512];
    logic [32:0] log_q [256];
    logic [7:0]  got_b [64];
    logic        got_l [64];
    int log_n = 0, nb = 0;
    int n_done = 0, n_int = 0, n_nodesc = 0, n_err = 0;
    int checks = 0, failures = 0;
    logic        err_en = 1'b0;
    logic [29:0] err_word = '0;
    logic        stall_mode = 1'b0;
    logic        tog = 1'b0;

    assign byte_ready = stall_mode ? tog : 1'b1;

    function automatic logic [7:0] pat(input int a);
        return 8'(a * 7 + 3);
    endfunction

    // memory responder: one request served every other cycle
    always @(posedge clk) begin
        tog <= ~tog;
        if (rst) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            mem_err <= err_en && (mem_addr[31:2] == err_word);
            if (mem_we) mem[mem_addr[10:2]] = mem_wdata;
            else mem_rdata <= mem[mem_addr[10:2]];
        end else begin
            mem_ack <= 1'b0;
            mem_err <= 1'b0;
        end
        if (mem_req && mem_ack && log_n < 256) begin
            log_q[log_n] = {mem_we, mem_addr};
            log_n = log_n + 1;
        end
        if (byte_valid && byte_ready && nb < 64) begin
            got_b[nb] = byte_data;
            got_l[nb] = byte_last;
            nb = nb + 1;
        end
        if (ev_frame_done) n_done = n_done + 1;
        if (ev_frame_int)  n_int = n_int + 1;
        if (ev_no_desc)    n_nodesc = n_nodesc + 1;
        if (ev_bus_err)    n_err = n_err + 1;
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put_desc(input int a, input logic [31:0] f, input logic [31:0] b,
                            input logic [31:0] sl, input logic [31:0] nx);
        mem[a/4]     = f;
        mem[a/4 + 1] = b;
        mem[a/4 + 2] = sl;
        mem[a/4 + 3] = nx;
    endtask

    task automatic pulse_sw_reset();
        @(negedge clk) sw_reset = 1'b1;
        @(negedge clk) sw_reset = 1'b0;
    endtask

    task automatic set_base(input logic [31:0] b);
        @(negedge clk) begin base_wr = 1'b1; base_data = b; end
        @(negedge clk) base_wr = 1'b0;
    endtask

    task automatic do_poll();
        @(negedge clk) poll = 1'b1;
        @(negedge clk) poll = 1'b0;
    endtask

    task automatic wait_stop(input int p_nd, input int p_er);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (n_nodesc != p_nd || n_err != p_er) return;
        end
        check(1'b0, "watchdog-run", 0, 1);
    endtask

    localparam logic [18:0] VEC [6] = '{
        {1'b1, 2'd0, 16'd5}, {1'b0, 2'd1, 16'd7}, {1'b1, 2'd2, 16'd1},
        {1'b1, 2'd3, 16'd9}, {1'b0, 2'd0, 16'd0}, {1'b0, 2'd2, 16'd16}
    };

    initial begin
        #2_000_000;
        check(1'b0, "watchdog-global", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int pn, pe, pd, pl, ln, off;
        logic ie;
        logic [31:0] exp_w;
        bit ok;
        for (int i = 0; i < 512; i++)
            mem[i] = {pat(4*i+3), pat(4*i+2), pat(4*i+1), pat(4*i)};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(mem_req == 1'b0 && byte_valid == 1'b0, "R1 idle outputs", {mem_req, byte_valid}, 0);
        check(cur_desc == 32'h0, "R1 cur_desc reset", cur_desc, 0);
        check(n_done + n_nodesc + n_err == 0, "R1 no events", n_done + n_nodesc + n_err, 0);

        // R2 poll with transmit disabled does nothing
        put_desc(32'h100, 32'h8000_0000, 32'h400, 32'd4, 32'h140);
        put_desc(32'h140, 32'h0, 32'h0, 32'h0, 32'h0);
        set_base(32'h100);
        do_poll();
        repeat (20) @(negedge clk);
        check(log_n == 0 && mem_req == 1'b0, "R2 poll ignored when disabled", log_n, 0);
        tx_enable = 1'b1;
        stall_mode = 1'b1;

        // table of single-descriptor cases
        for (int v = 0; v < 6; v++) begin
            ie  = VEC[v][18];
            off = int'(VEC[v][17:16]);
            ln  = int'(VEC[v][15:0]);
            pulse_sw_reset();
            put_desc(32'h100, 32'h8000_1000 | (32'(ie) << 2), 32'h400 + 32'(off),
                     32'h0A00_0000 | 32'(ln), 32'h140);
            put_desc(32'h140, 32'h0, 32'h0, 32'h0, 32'h0);
            for (int k = 256; k < 264; k++)
                mem[k] = {pat(4*k+3), pat(4*k+2), pat(4*k+1), pat(4*k)};
            set_base(32'h100);
            nb = 0; pn = n_nodesc; pe = n_err; pd = n_done;
            do_poll();
            wait_stop(pn, pe);
            check(nb == ln, "R4 byte count", nb, ln);
            ok = 1'b1;
            for (int b = 0; b < nb && b < 64; b++) begin
                if (got_b[b] != pat(32'h400 + off + b)) ok = 1'b0;
                if (got_l[b] != (b == ln - 1)) ok = 1'b0;
            end
            check(ok, "R4 payload bytes and last", v, 1);
            exp_w = 32'h0A08_0000 | (32'(ie) << 16) | 32'(ln);
            check(mem[32'h108/4] == exp_w, "R5 status write-back", mem[32'h108/4], exp_w);
            exp_w = 32'h0000_1000 | (32'(ie) << 2);
            check(mem[32'h100/4] == exp_w, "R5 flags write-back", mem[32'h100/4], exp_w);
            check(n_done - pd == 1 && n_int == n_done, "R6 one frame event", n_done - pd, 1);
            check(cur_desc == 32'h140, "R3 stop pointer", cur_desc, 32'h140);
        end

        // chain with non-adjacent links, mid-run poll
        pulse_sw_reset();
        put_desc(32'h100, 32'h8000_0004, 32'h400, 32'd6, 32'h180);
        put_desc(32'h180, 32'h8000_0000, 32'h481, 32'd5, 32'h140);
        put_desc(32'h140, 32'h0, 32'h0, 32'h0, 32'h0);
        set_base(32'h100);
        nb = 0; pn = n_nodesc; pe = n_err; pd = n_done; pl = log_n;
        do_poll();
        repeat (6) @(negedge clk);
        do_poll();
        wait_stop(pn, pe);
        repeat (40) @(negedge clk);
        check(n_nodesc - pn == 1, "R10 poll during run ignored", n_nodesc - pn, 1);
        check(log_q[pl] == {1'b0, 32'h100} && log_q[pl+1] == {1'b0, 32'h104}
              && log_q[pl+2] == {1'b0, 32'h108} && log_q[pl+3] == {1'b0, 32'h10C},
              "R2 fetch order", log_q[pl+3], {1'b0, 32'h10C});
        check(log_q[pl+6] == {1'b1, 32'h108} && log_q[pl+7] == {1'b1, 32'h100},
              "R5 status before flags", log_q[pl+6], {1'b1, 32'h108});
        check(log_q[pl+8] == {1'b0, 32'h180}, "R7 follows next link", log_q[pl+8], {1'b0, 32'h180});
        check(n_done - pd == 2, "R6 two frames", n_done - pd, 2);
        ok = (nb == 11);
        for (int b = 0; b < 11; b++) begin
            if (got_b[b] != (b < 6 ? pat(32'h400 + b) : pat(32'h481 + b - 6))) ok = 1'b0;
            if (got_l[b] != (b == 5 || b == 10)) ok = 1'b0;
        end
        check(ok, "R11 stalled stream intact", nb, 11);
        check(cur_desc == 32'h140, "R3 chain stop pointer", cur_desc, 32'h140);

        // late base write ignored, poll resumes at stopped descriptor
        set_base(32'h200);
        put_desc(32'h140, 32'h8000_0000, 32'h410, 32'd2, 32'h1C0);
        put_desc(32'h1C0, 32'h0, 32'h0, 32'h0, 32'h0);
        pn = n_nodesc; pe = n_err; pl = log_n;
        do_poll();
        wait_stop(pn, pe);
        check(log_q[pl] == {1'b0, 32'h140}, "R8 base write ignored", log_q[pl], {1'b0, 32'h140});
        check(cur_desc == 32'h1C0, "R10 resume run", cur_desc, 32'h1C0);

        // bus error during payload read
        pulse_sw_reset();
        put_desc(32'h100, 32'h8000_0000, 32'h420, 32'd8, 32'h140);
        put_desc(32'h140, 32'h0, 32'h0, 32'h0, 32'h0);
        set_base(32'h100);
        err_en = 1'b1; err_word = 30'(32'h420 >> 2);
        nb = 0; pn = n_nodesc; pe = n_err;
        do_poll();
        wait_stop(pn, pe);
        err_en = 1'b0;
        check(n_err - pe == 1 && nb == 0, "R9 error event", n_err - pe, 1);
        check(mem[32'h100/4] == 32'h8000_0000, "R9 no write-back", mem[32'h100/4], 32'h8000_0000);
        pl = log_n;
        do_poll();
        repeat (20) @(negedge clk);
        check(log_n == pl && mem_req == 1'b0, "R9 halted ignores poll", log_n - pl, 0);
        pulse_sw_reset();
        check(cur_desc == 32'h0, "R1 sw_reset clears pointer", cur_desc, 0);
        set_base(32'h100);
        pn = n_nodesc; pe = n_err; pd = n_done;
        do_poll();
        wait_stop(pn, pe);
        check(n_done - pd == 1, "R9 recovery after sw_reset", n_done - pd, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule